// File: doc/BRIEF.md
# Scanline IRQ Down-Counter

This block generates a raster interrupt by counting scanlines. Each single-cycle `tick` stands for one scanline. An 8-bit down-counter counts those ticks. When the counter is empty, or when software has requested a reload, the next tick loads the counter from a programmable latch. When the counter steps from a nonzero value to zero while interrupts are enabled, a level interrupt output is raised. It stays raised until software acknowledges it.

Software controls the counter through two aliased register windows that act on the same state:

- An extended register page, 64 bytes at `EXT_BASE`, decoded with `wr_addr[5:0]` as the offset. A latch write through this page clears the latch's least significant bit.
- A cartridge-style window in the upper half of the address space. It is decoded only on `wr_addr[15:13]` and `wr_addr[0]`, so it mirrors throughout its range.

The CPU bus reaches the block as a write strobe, a 16-bit address and a data byte.

Top module: `scanline_irq_counter`

## Requirements
- R1: On a cycle with `tick` high, the count loads from the latch if it is zero or if the reload flag is set, and the reload flag clears. Otherwise the count decreases by one. Without `tick` the count holds.
- R2: `irq` is raised only on a tick where the count was nonzero before the tick, is zero after it, and enable is set. Loading a zero latch into a zero count never raises it. Loading a zero latch over a nonzero count does raise it.
- R3: Once raised, `irq` stays high across further ticks until an acknowledge write.
- R4: A write to extended page offset 1 (address `EXT_BASE+1`) loads the latch with data bit 0 forced to 0.
- R5: A write with `wr_addr[15:13]=110` and `wr_addr[0]=0` (for example 0xC000 or 0xDFFE) loads the full 8-bit latch.
- R6: A write to extended offset 2, or to `wr_addr[15:13]=110` with `wr_addr[0]=1` (0xC001), sets the reload flag.
- R7: A write to extended offset 3, or to `wr_addr[15:13]=111` with `wr_addr[0]=0` (0xE000), clears enable and deasserts `irq`. The count keeps running.
- R8: A write to extended offset 4, or to `wr_addr[15:13]=111` with `wr_addr[0]=1` (0xE001), sets enable.
- R9: Reset clears latch, count, reload flag, enable and `irq`.
- R10: When a write and a tick fall in the same cycle, the write takes effect first and the tick then acts on the updated state.
- R11: Writes to other addresses have no effect. These include extended offsets other than 1 to 4, addresses outside the page, and 0x8000 to 0xBFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | W | Write data |
| tick | input | 1 | One-cycle scanline strobe |
| irq | output | 1 | Level interrupt request |

## Verification
None of the internal state leaves the block except through `irq`, so any error shows up as a wrong number of ticks between programming and the rise of `irq`, or as a rise that should not happen. A corrupted latch value, a lost reload flag or a missed decrement each shifts that rise by at least one tick. This shift is visible within latch-plus-one scanlines. A wrong enable or acknowledge shows up one cycle after the tick or write concerned, as `irq` at the wrong level.

// File: rtl/scanline_irq_counter.sv
module scanline_irq_counter #(
  parameter int          W        = 8,
  parameter logic [15:0] EXT_BASE = 16'h4100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [15:0]  wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  output logic         irq
);
  logic [W-1:0] latch_q, cnt_q, latch_nx, cnt_nx;
  logic         reload_q, en_q, irq_q, reload_nx, en_nx, fire;

  wire       ext_hit  = wr_en && (wr_addr[15:6] == EXT_BASE[15:6]);
  wire [5:0] ext_off  = wr_addr[5:0];
  wire       cart_hit = wr_en && wr_addr[15];
  wire [2:0] cart_sel = {wr_addr[14:13], wr_addr[0]};

  wire w_latch_ext  = ext_hit  && ext_off == 6'd1;
  wire w_latch_cart = cart_hit && cart_sel == 3'b100;
  wire w_reload     = (ext_hit && ext_off == 6'd2) || (cart_hit && cart_sel == 3'b101);
  wire w_ack        = (ext_hit && ext_off == 6'd3) || (cart_hit && cart_sel == 3'b110);
  wire w_enable     = (ext_hit && ext_off == 6'd4) || (cart_hit && cart_sel == 3'b111);

  assign latch_nx  = w_latch_ext  ? {wr_data[W-1:1], 1'b0} :
                     w_latch_cart ? wr_data : latch_q;
  assign reload_nx = reload_q | w_reload;
  assign en_nx     = w_ack ? 1'b0 : (w_enable ? 1'b1 : en_q);

  always_comb begin
    cnt_nx = cnt_q;
    if (tick) cnt_nx = (reload_nx || cnt_q == '0) ? latch_nx : cnt_q - 1'b1;
  end

  assign fire = tick && (cnt_q != '0) && (cnt_nx == '0) && en_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q  <= '0;
      cnt_q    <= '0;
      reload_q <= 1'b0;
      en_q     <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      latch_q  <= latch_nx;
      cnt_q    <= cnt_nx;
      reload_q <= tick ? 1'b0 : reload_nx;
      en_q     <= en_nx;
      irq_q    <= (irq_q && !w_ack) || fire;
    end
  end

  assign irq = irq_q;
endmodule

module scanline_irq_counter_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [15:0]  wr_addr,
  input logic         tick,
  input logic         irq,
  input logic [W-1:0] cnt,
  input logic         reload
);
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt)); // R1
  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt != '0 && !reload && !wr_en) |=> (cnt == W'($past(cnt) - 1'b1))); // R1
  AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick)); // R2
  AST_RISE_FROM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cnt) != '0)); // R2
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> irq); // R3
  AST_RELOAD_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !reload); // R6
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 16'hE000) |=> !irq); // R7
endmodule

bind scanline_irq_counter scanline_irq_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .tick(tick), .irq(irq), .cnt(cnt_q), .reload(reload_q)
);

// File: tb/scanline_irq_counter_test.sv
`timescale 1ns/1ps
module scanline_irq_counter_test;
  logic        clk = 0, rst_n = 0, wr_en = 0, tick = 0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        irq;
  int checks = 0, errors = 0;

  scanline_irq_counter uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                            .wr_data(wr_data), .tick(tick), .irq(irq));

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; wr_en = 0; tick = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic wr_tick(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d; tick = 1;
    @(negedge clk); wr_en = 0; tick = 0;
  endtask

  task automatic ticks_to_irq(input int lim, output int n);
    n = 0;
    for (int i = 0; i < lim; i++) begin
      pulse(); n++;
      if (irq) return;
    end
    n = -1;
  endtask

  task automatic t_reset();
    int n;
    do_reset();
    check(irq == 0, "R9 irq after reset", irq, 0);
    wr(16'hC000, 8'd2);
    ticks_to_irq(6, n);
    check(n == -1, "R9 enable cleared by reset", n, -1);
    do_reset();
    wr(16'hE001, 0);
    ticks_to_irq(6, n);
    check(n == -1, "R9 latch cleared by reset", n, -1);
  endtask

  task automatic t_cart_latch();
    int n;
    do_reset();
    wr(16'hC000, 8'd5); wr(16'hE001, 0);
    ticks_to_irq(20, n);
    check(n == 6, "R5 R8 R1 cart latch 5", n, 6);
    do_reset();
    wr(16'hDFFE, 8'd3); wr(16'hFFFF, 0);
    ticks_to_irq(20, n);
    check(n == 4, "R5 mirrored cart latch 3", n, 4);
  endtask

  task automatic t_ext_latch();
    int n;
    do_reset();
    wr(16'h4101, 8'd5); wr(16'h4104, 0);
    ticks_to_irq(20, n);
    check(n == 5, "R4 R8 ext latch bit0 cleared", n, 5);
  endtask

  task automatic t_level_ack();
    int n;
    do_reset();
    wr(16'hC000, 8'd2); wr(16'hE001, 0);
    ticks_to_irq(20, n);
    check(n == 3, "R2 irq after latch 2", n, 3);
    pulse(); pulse(); pulse();
    check(irq == 1, "R3 irq held across ticks", irq, 1);
    wr(16'hE000, 0);
    check(irq == 0, "R7 cart ack deasserts", irq, 0);
    ticks_to_irq(8, n);
    check(n == -1, "R7 enable cleared by ack", n, -1);
    wr(16'h4104, 0);
    ticks_to_irq(8, n);
    check(n > 0, "R8 ext enable resumes irq", n, 1);
    wr(16'h4103, 0);
    check(irq == 0, "R7 ext ack deasserts", irq, 0);
  endtask

  task automatic t_reload();
    int n;
    do_reset();
    wr(16'hC000, 8'd3); wr(16'hE001, 0);
    pulse(); pulse();
    wr(16'hC001, 0);
    ticks_to_irq(20, n);
    check(n == 4, "R6 cart reload restarts count", n, 4);
    wr(16'hE000, 0); wr(16'hE001, 0);
    pulse();
    wr(16'h4102, 0);
    ticks_to_irq(20, n);
    check(n == 4, "R6 ext reload restarts count", n, 4);
  endtask

  task automatic t_zero_latch();
    int n;
    do_reset();
    wr(16'hE001, 0);
    ticks_to_irq(5, n);
    check(n == -1, "R2 zero latch from zero count", n, -1);
    wr(16'hC000, 8'd3); wr(16'hC001, 0);
    pulse(); pulse();
    check(irq == 0, "R2 no irq mid-count", irq, 0);
    wr(16'hC000, 8'd0); wr(16'hC001, 0);
    pulse();
    check(irq == 1, "R2 zero latch over nonzero count", irq, 1);
  endtask

  task automatic t_same_cycle();
    int n;
    do_reset();
    wr(16'hC000, 8'd2); wr(16'hE001, 0);
    pulse(); pulse();
    wr_tick(16'hE000, 0);
    check(irq == 0, "R10 disable before firing tick", irq, 0);
    do_reset();
    wr(16'hC000, 8'd2); wr(16'hE001, 0);
    pulse(); pulse();
    wr_tick(16'hC001, 0);
    check(irq == 0, "R10 reload before firing tick", irq, 0);
    ticks_to_irq(10, n);
    check(n == 2, "R10 count after same-cycle reload", n, 2);
    do_reset();
    wr(16'hE001, 0);
    wr_tick(16'hC000, 8'd1);
    ticks_to_irq(10, n);
    check(n == 1, "R10 latch write seen by same tick", n, 1);
  endtask

  task automatic t_ignored();
    int n;
    do_reset();
    wr(16'hC000, 8'd2); wr(16'hE001, 0);
    wr(16'h4141, 8'd0); wr(16'h4142, 0); wr(16'h4105, 8'd0);
    wr(16'h8000, 8'd0); wr(16'h8001, 8'd0); wr(16'hA000, 0); wr(16'hA001, 0);
    wr(16'h0101, 8'd0); wr(16'h0103, 0);
    ticks_to_irq(20, n);
    check(n == 3, "R11 unrelated writes ignored", n, 3);
    wr(16'h4143, 0); wr(16'hA001, 0);
    check(irq == 1, "R11 no false ack", irq, 1);
  endtask

  initial begin
    t_reset();
    t_cart_latch();
    t_ext_latch();
    t_level_ack();
    t_reload();
    t_zero_latch();
    t_same_cycle();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule